// File: doc/BRIEF.md
# TDM Timeslot Slave Port

This block attaches a chip to a frame-synchronised time-division serial bus as a pure slave. A bus data clock and a frame strobe arrive as inputs; the block follows the bit and timeslot position inside each frame, picks received bytes off the downstream line and places transmit bytes on the upstream line in the timeslots given to it. Every timeslot carries eight bits, shifted MSB first, and a frame nominally repeats every 125 µs.

Up to four channels can be mapped onto the frame. Each channel has a start slot and a sample format. The two companded formats and a spare code use one slot. The linear format uses two adjacent slots, high byte first. Received words come out with a one-cycle valid pulse. Transmit words are taken from per-channel holding inputs when the channel's first slot begins. The bus clock can run at the bit rate or at twice the bit rate. With the usual terminal layout of twelve slots, the voice channels sit at slots 0/1 and the intercom pair at slots 4/5.

The block runs on a system clock `clk_i` that is faster than the bus clock. Bus clock and frame strobe must already be synchronous to `clk_i`, with each bus clock phase lasting at least two system cycles.

Top module: `tdm_slot_slave`

## Requirements
- R1: A frame starts at the bus clock rising edge where `fsc_i` is sampled high after being low at the previous rising edge. That bus clock period is bit 0 of slot 0. The width of the strobe pulse has no effect, and neither does raising it early while the bus clock is low.
- R2: In single-clock mode (`dbl_clk_i`=0) each bit lasts one bus clock period. `dout_o`/`doe_o` update on the rising edge, `din_i` is sampled on the falling edge, and bytes are shifted MSB first.
- R3: In double-clock mode (`dbl_clk_i`=1) each bit lasts two bus clock periods. Transmit data is set at the start of the first period, and `din_i` is sampled on the falling edge of the second period.
- R4: Slots are 8 bits wide and are numbered from 0. Slots at or beyond `num_slots_i` are neither driven nor received. A linear channel whose second slot lies out of range never reports a word.
- R5: `doe_o` is 1 only during slots that an enabled channel owns. When it is released, `dout_o` is 1.
- R6: The format field is 2 bits per channel. Codes 0, 1 and 3 occupy only the start slot. Code 2 occupies the start slot and the next slot, high byte first.
- R7: One system cycle after the last bit of a channel's word is sampled, `rx_valid_o[c]` pulses for one cycle. The word is `{hi,lo}` for code 2 and `{8'h00,byte}` otherwise, in `rx_data_o[16c+:16]`.
- R8: `tx_data_i[16c+:16]` is latched at the first bit of the channel's start slot. A change after that point affects only later frames. One-slot formats send the low byte.
- R9: A channel with `ch_en_i[c]`=0 drives no slot and never raises `rx_valid_o[c]`.
- R10: When several enabled channels claim the same slot, the lowest-index channel drives it, and every one of them receives the byte and reports it in the same cycle.
- R11: Until the first frame strobe edge after reset, nothing is driven and nothing is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dcl_i | input | 1 | Bus data clock, synchronous to clk_i |
| fsc_i | input | 1 | Frame strobe |
| dbl_clk_i | input | 1 | 1 = two bus clock periods per bit |
| num_slots_i | input | SLW+1 | Slots per frame |
| ch_en_i | input | NCH | Channel enables |
| ch_slot_i | input | NCH*SLW | Start slot per channel |
| ch_fmt_i | input | 2*NCH | Format per channel (2 = 16-bit linear) |
| tx_data_i | input | 16*NCH | Transmit holding words |
| din_i | input | 1 | Downstream serial data |
| dout_o | output | 1 | Upstream serial data |
| doe_o | output | 1 | Upstream output enable |
| rx_data_o | output | 16*NCH | Received words |
| rx_valid_o | output | NCH | Received word strobes |

## Verification
Two things can happen in the same system cycle: slot arbitration on the transmit side, and word completion for more than one channel on the receive side. To provoke both, the bench maps two enabled channels onto one slot and gives them different transmit words. It then checks that the upstream byte is the lower channel's word, and that both valid pulses carry the same received byte and fall on the same timestamp. The other scenarios change the strobe shape, the clock mode, the slot limit and the timing of a holding-word update, and check at the pins that each change has the expected effect.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;
  typedef enum logic [1:0] {
    FMT_ALAW  = 2'd0,
    FMT_ULAW  = 2'd1,
    FMT_LIN16 = 2'd2,
    FMT_SPARE = 2'd3
  } smp_fmt_e;

  function automatic logic fmt_is_wide(logic [1:0] f);
    return f == FMT_LIN16;
  endfunction
endpackage

// File: rtl/tdm_slot_timing.sv
module tdm_slot_timing #(
  parameter int MAX_SLOTS = 32,
  parameter int SLW       = $clog2(MAX_SLOTS)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           dcl_i,
  input  logic           fsc_i,
  input  logic           dbl_i,
  input  logic [SLW:0]   num_slots_i,
  output logic           dcl_rise_o,
  output logic           tx_stb_o,
  output logic           tx_lead_o,
  output logic [SLW-1:0] tx_slot_o,
  output logic [2:0]     tx_bit_o,
  output logic           rx_stb_o,
  output logic [SLW-1:0] rx_slot_o,
  output logic [2:0]     rx_bit_o
);
  localparam int PW  = $clog2(MAX_SLOTS * 16) + 1;
  localparam int SFW = PW - 3;

  logic          dcl_q, fsc_q, live_q, live_n;
  logic          dcl_fall, fsc_edge;
  logic [PW-1:0] pos_q, pos_n;
  logic [SFW-1:0] tx_sf, rx_sf, lim;

  function automatic logic [PW-1:0] bit_pos(logic [PW-1:0] p, logic dbl);
    return dbl ? (p >> 1) : p;
  endfunction

  always_comb begin
    dcl_rise_o = dcl_i & ~dcl_q;
    dcl_fall   = ~dcl_i & dcl_q;
    fsc_edge   = fsc_i & ~fsc_q;
    live_n     = live_q | fsc_edge;
    if (fsc_edge)          pos_n = '0;
    else if (pos_q == '1)  pos_n = pos_q;   // hold past end of frame
    else                   pos_n = pos_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcl_q  <= 1'b0;
      fsc_q  <= 1'b0;
      live_q <= 1'b0;
      pos_q  <= '1;
    end else begin
      dcl_q <= dcl_i;
      if (dcl_rise_o) begin
        fsc_q  <= fsc_i;
        live_q <= live_n;
        pos_q  <= pos_n;
      end
    end
  end

  always_comb begin
    logic [PW-1:0] tb, rb;
    lim       = SFW'(num_slots_i);
    tb        = bit_pos(pos_n, dbl_i);
    rb        = bit_pos(pos_q, dbl_i);
    tx_sf     = tb[PW-1:3];
    rx_sf     = rb[PW-1:3];
    tx_slot_o = tx_sf[SLW-1:0];
    rx_slot_o = rx_sf[SLW-1:0];
    tx_bit_o  = tb[2:0];
    rx_bit_o  = rb[2:0];
    tx_lead_o = ~dbl_i | ~pos_n[0];
    tx_stb_o  = dcl_rise_o & live_n & (tx_sf < lim);
    rx_stb_o  = dcl_fall & live_q & (rx_sf < lim) & (~dbl_i | pos_q[0]);
  end

  // R1: a strobe edge seen at a bus clock rise restarts the frame position
  a_r1_frame_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dcl_rise_o && fsc_i && !fsc_q) |=> (pos_q == '0));
endmodule

// File: rtl/tdm_slot_chmap.sv
module tdm_slot_chmap
  import tdm_slot_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SLW = 5
) (
  input  logic [SLW-1:0]     slot_i,
  input  logic [NCH-1:0]     ch_en_i,
  input  logic [NCH*SLW-1:0] ch_slot_i,
  input  logic [2*NCH-1:0]   ch_fmt_i,
  output logic [NCH-1:0]     first_o,
  output logic [NCH-1:0]     second_o,
  output logic [NCH-1:0]     wide_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [SLW-1:0] base;
    assign base        = ch_slot_i[c*SLW +: SLW];
    assign wide_o[c]   = fmt_is_wide(ch_fmt_i[2*c +: 2]);
    assign first_o[c]  = ch_en_i[c] && (slot_i == base);
    assign second_o[c] = ch_en_i[c] && wide_o[c] &&
                         ({1'b0, slot_i} == ({1'b0, base} + (SLW+1)'(1)));
  end
endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx #(
  parameter int NCH = 4,
  parameter int SLW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dcl_rise_i,
  input  logic              tx_stb_i,
  input  logic              tx_lead_i,
  input  logic [2:0]        bit_i,
  input  logic [NCH-1:0]    first_i,
  input  logic [NCH-1:0]    second_i,
  input  logic [NCH-1:0]    wide_i,
  input  logic [16*NCH-1:0] tx_data_i,
  output logic              dout_o,
  output logic              doe_o
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] load;
  logic [15:0]    word_q [NCH];
  logic           own_any, own_hi, tx_bit;
  logic [CW-1:0]  own;
  logic [15:0]    src;

  for (genvar c = 0; c < NCH; c++) begin : g_word
    assign load[c] = tx_stb_i & tx_lead_i & (bit_i == 3'd0) & first_i[c];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      word_q[c] <= '0;
      else if (load[c]) word_q[c] <= tx_data_i[16*c +: 16];
    end
  end

  // lowest index wins a shared slot
  always_comb begin
    own_any = 1'b0;
    own_hi  = 1'b0;
    own     = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (first_i[c] || second_i[c]) begin
        own_any = 1'b1;
        own     = CW'(c);
        own_hi  = first_i[c] & wide_i[c];
      end
    end
    src    = load[own] ? tx_data_i[16*own +: 16] : word_q[own];
    tx_bit = src[{own_hi, ~bit_i}];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      doe_o  <= 1'b0;
      dout_o <= 1'b1;
    end else if (dcl_rise_i) begin
      if (tx_stb_i && own_any) begin
        doe_o  <= 1'b1;
        dout_o <= tx_bit;
      end else begin
        doe_o  <= 1'b0;
        dout_o <= 1'b1;
      end
    end
  end

  // R5: upstream pins move only on a bus clock rising edge
  a_r5_hold_between_edges: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dcl_rise_i |=> ($stable(doe_o) && $stable(dout_o)));
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx #(
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_stb_i,
  input  logic [2:0]        bit_i,
  input  logic              din_i,
  input  logic [NCH-1:0]    first_i,
  input  logic [NCH-1:0]    second_i,
  input  logic [NCH-1:0]    wide_i,
  output logic [16*NCH-1:0] rx_data_o,
  output logic [NCH-1:0]    rx_valid_o
);
  logic [6:0] sr_q;
  logic [7:0] byte_w;
  logic       done;

  assign byte_w = {sr_q, din_i};
  assign done   = rx_stb_i && (bit_i == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (rx_stb_i) sr_q <= byte_w[6:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [7:0]  hi_q;
    logic [15:0] dat_q;
    logic        vld_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q  <= '0;
        dat_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= done & ((first_i[c] & ~wide_i[c]) | second_i[c]);
        if (done && first_i[c] && wide_i[c])  hi_q  <= byte_w;
        if (done && first_i[c] && !wide_i[c]) dat_q <= {8'h00, byte_w};
        if (done && second_i[c])              dat_q <= {hi_q, byte_w};
      end
    end
    assign rx_data_o[16*c +: 16] = dat_q;
    assign rx_valid_o[c]         = vld_q;
  end

  // R7: word strobes are single-cycle pulses
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o != '0) |=> (rx_valid_o == '0));
  // R7: a word strobe follows the sample of a slot's last bit
  a_r7_after_last_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o != '0) |-> $past(rx_stb_i && (bit_i == 3'd7)));
endmodule

// File: rtl/tdm_slot_slave.sv
module tdm_slot_slave #(
  parameter int NCH       = 4,
  parameter int MAX_SLOTS = 32,
  parameter int SLW       = $clog2(MAX_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dcl_i,
  input  logic              fsc_i,
  input  logic              dbl_clk_i,
  input  logic [SLW:0]      num_slots_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH*SLW-1:0] ch_slot_i,
  input  logic [2*NCH-1:0]  ch_fmt_i,
  input  logic [16*NCH-1:0] tx_data_i,
  input  logic              din_i,
  output logic              dout_o,
  output logic              doe_o,
  output logic [16*NCH-1:0] rx_data_o,
  output logic [NCH-1:0]    rx_valid_o
);
  logic           dcl_rise, tx_stb, tx_lead, rx_stb;
  logic [SLW-1:0] tx_slot, rx_slot;
  logic [2:0]     tx_bit, rx_bit;
  logic [NCH-1:0] tx_first, tx_second, tx_wide;
  logic [NCH-1:0] rx_first, rx_second, rx_wide;

  tdm_slot_timing #(.MAX_SLOTS(MAX_SLOTS), .SLW(SLW)) u_timing (
    .clk_i, .rst_ni, .dcl_i, .fsc_i,
    .dbl_i       (dbl_clk_i),
    .num_slots_i,
    .dcl_rise_o  (dcl_rise),
    .tx_stb_o    (tx_stb),
    .tx_lead_o   (tx_lead),
    .tx_slot_o   (tx_slot),
    .tx_bit_o    (tx_bit),
    .rx_stb_o    (rx_stb),
    .rx_slot_o   (rx_slot),
    .rx_bit_o    (rx_bit)
  );

  tdm_slot_chmap #(.NCH(NCH), .SLW(SLW)) u_map_tx (
    .slot_i (tx_slot), .ch_en_i, .ch_slot_i, .ch_fmt_i,
    .first_o(tx_first), .second_o(tx_second), .wide_o(tx_wide)
  );

  tdm_slot_chmap #(.NCH(NCH), .SLW(SLW)) u_map_rx (
    .slot_i (rx_slot), .ch_en_i, .ch_slot_i, .ch_fmt_i,
    .first_o(rx_first), .second_o(rx_second), .wide_o(rx_wide)
  );

  tdm_slot_tx #(.NCH(NCH), .SLW(SLW)) u_tx (
    .clk_i, .rst_ni,
    .dcl_rise_i(dcl_rise),
    .tx_stb_i  (tx_stb),
    .tx_lead_i (tx_lead),
    .bit_i     (tx_bit),
    .first_i   (tx_first),
    .second_i  (tx_second),
    .wide_i    (tx_wide),
    .tx_data_i,
    .dout_o, .doe_o
  );

  tdm_slot_rx #(.NCH(NCH)) u_rx (
    .clk_i, .rst_ni,
    .rx_stb_i (rx_stb),
    .bit_i    (rx_bit),
    .din_i,
    .first_i  (rx_first),
    .second_i (rx_second),
    .wide_i   (rx_wide),
    .rx_data_o, .rx_valid_o
  );

  // R9: a channel disabled during the completing sample never reports
  a_r9_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o & ~$past(ch_en_i)) == '0);
endmodule

// File: tb/tdm_slot_slave_bench.sv
module tdm_slot_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int SLW = 5;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic dcl_i = 1'b0, fsc_i = 1'b0, dbl_clk_i = 1'b0, din_i = 1'b0;
  logic [SLW:0]       num_slots_i = 6'd12;
  logic [NCH-1:0]     ch_en_i = '0;
  logic [NCH*SLW-1:0] ch_slot_i = '0;
  logic [2*NCH-1:0]   ch_fmt_i = '0;
  logic [16*NCH-1:0]  tx_data_i = '0;
  logic dout_o, doe_o;
  logic [16*NCH-1:0]  rx_data_o;
  logic [NCH-1:0]     rx_valid_o;

  tdm_slot_slave u_tdm_slot_slave (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic got_do [768];
  logic got_oe [768];
  logic [7:0] din_byte [32];
  int vcnt [NCH];
  int vbase [NCH];
  logic [15:0] vdat [NCH];
  time vt [NCH];

  initial for (int c = 0; c < NCH; c++) vcnt[c] = 0;

  always @(negedge clk_i)
    for (int c = 0; c < NCH; c++)
      if (rx_valid_o[c]) begin
        vcnt[c] = vcnt[c] + 1;
        vdat[c] = rx_data_o[16*c +: 16];
        vt[c]   = $time;
      end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_ch(input int c, input bit en, input int slot, input int fmt, input logic [15:0] w);
    ch_en_i[c] = en;
    ch_slot_i[c*SLW +: SLW] = SLW'(slot);
    ch_fmt_i[2*c +: 2] = 2'(fmt);
    tx_data_i[16*c +: 16] = w;
  endtask

  task automatic fill_din(input int seed);
    for (int s = 0; s < 32; s++) din_byte[s] = 8'((s * 37 + seed) ^ 8'h5A);
  endtask

  // nrun slots of bus clock; fw = strobe periods; early raises the strobe while dcl is low
  task automatic run_frame(input int nrun, input bit dbl, input int fw, input bit early,
                           input int chg_p, input int chg_ch, input logic [15:0] chg_v);
    int np;
    dbl_clk_i = dbl;
    np = nrun * 8 * (dbl ? 2 : 1);
    for (int c = 0; c < NCH; c++) vbase[c] = vcnt[c];
    for (int i = 0; i < 768; i++) begin got_do[i] = 1'bx; got_oe[i] = 1'b0; end
    if (early && fw > 0) begin
      @(negedge clk_i); fsc_i = 1'b1;
      repeat (2) @(negedge clk_i);
    end
    for (int p = 0; p < np; p++) begin
      int b;
      b = dbl ? p / 2 : p;
      if (p == chg_p) tx_data_i[16*chg_ch +: 16] = chg_v;
      @(negedge clk_i);
      dcl_i = 1'b1;
      din_i = din_byte[b / 8][7 - (b % 8)];
      fsc_i = (p < fw);
      repeat (2) @(negedge clk_i);
      if (!dbl || (p % 2 == 0)) begin got_do[b] = dout_o; got_oe[b] = doe_o; end
      repeat (2) @(negedge clk_i);
      dcl_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic chk_tx(input int s, input logic [7:0] exp, input string req);
    logic [7:0] act;
    int oe;
    oe = 0;
    for (int k = 0; k < 8; k++) begin act[7-k] = got_do[s*8+k]; oe += int'(got_oe[s*8+k]); end
    chk(oe == 8, req, $sformatf("slot %0d enable bits", s), oe, 8);
    chk(act === exp, req, $sformatf("slot %0d tx byte", s), act, exp);
  endtask

  task automatic chk_idle(input int s, input string req);
    int oe;
    bit hi;
    oe = 0; hi = 1;
    for (int k = 0; k < 8; k++) begin oe += int'(got_oe[s*8+k]); if (got_do[s*8+k] !== 1'b1) hi = 0; end
    chk(oe == 0 && hi, req, $sformatf("slot %0d released", s), oe, 0);
  endtask

  task automatic chk_rx(input int c, input int n, input logic [15:0] exp, input string req);
    chk(vcnt[c] - vbase[c] == n, req, $sformatf("ch%0d word count", c), vcnt[c] - vbase[c], n);
    if (n > 0) chk(vdat[c] === exp, req, $sformatf("ch%0d rx word", c), vdat[c], exp);
  endtask

  task automatic t_reset;
    chk(doe_o === 1'b0, "R5", "reset doe", doe_o, 0);
    chk(dout_o === 1'b1, "R5", "reset dout", dout_o, 1);
    chk(rx_valid_o === '0, "R7", "reset valid", rx_valid_o, 0);
  endtask

  task automatic t_unsynced;  // R11
    num_slots_i = 6'd4;
    ch_en_i = '0;
    cfg_ch(0, 1, 0, 0, 16'h00C3);
    fill_din(1);
    run_frame(4, 0, 0, 0, -1, 0, 0);
    chk_idle(0, "R11");
    chk_rx(0, 0, 0, "R11");
  endtask

  task automatic terminal_cfg;
    ch_en_i = '0;
    num_slots_i = 6'd12;
    cfg_ch(0, 1, 0, 0, 16'h00A5);
    cfg_ch(1, 1, 1, 1, 16'h003C);
    cfg_ch(2, 1, 4, 2, 16'hBEEF);
    cfg_ch(3, 1, 8, 3, 16'h1281);
  endtask

  task automatic terminal_check(input string req);
    chk_tx(0, 8'hA5, req);
    chk_tx(1, 8'h3C, req);
    chk_tx(4, 8'hBE, "R6");
    chk_tx(5, 8'hEF, "R6");
    chk_tx(8, 8'h81, "R8");
    chk_idle(2, "R5"); chk_idle(7, "R5"); chk_idle(11, "R5");
    chk_rx(0, 1, {8'h00, din_byte[0]}, req);
    chk_rx(1, 1, {8'h00, din_byte[1]}, "R7");
    chk_rx(2, 1, {din_byte[4], din_byte[5]}, "R6");
    chk_rx(3, 1, {8'h00, din_byte[8]}, "R7");
  endtask

  task automatic t_single;  // R1 R2 R6 R7
    terminal_cfg();
    fill_din(3);
    run_frame(12, 0, 1, 0, -1, 0, 0);
    terminal_check("R2");
  endtask

  task automatic t_double;  // R3
    terminal_cfg();
    fill_din(9);
    run_frame(12, 1, 2, 0, -1, 0, 0);
    terminal_check("R3");
  endtask

  task automatic t_strobe_shape;  // R1
    terminal_cfg();
    fill_din(17);
    run_frame(12, 0, 6, 1, -1, 0, 0);
    chk_tx(0, 8'hA5, "R1");
    chk_rx(0, 1, {8'h00, din_byte[0]}, "R1");
    chk_rx(2, 1, {din_byte[4], din_byte[5]}, "R1");
  endtask

  task automatic t_slot_limit;  // R4
    ch_en_i = '0;
    num_slots_i = 6'd4;
    cfg_ch(2, 1, 3, 2, 16'h5AC7);
    cfg_ch(3, 1, 8, 0, 16'h0077);
    fill_din(23);
    run_frame(10, 0, 1, 0, -1, 0, 0);
    chk_tx(3, 8'h5A, "R4");
    chk_idle(4, "R4");
    chk_idle(8, "R4");
    chk_rx(2, 0, 0, "R4");
    chk_rx(3, 0, 0, "R4");
  endtask

  task automatic t_tx_latch;  // R8
    terminal_cfg();
    fill_din(31);
    run_frame(12, 0, 1, 0, 4*8 + 3, 2, 16'h1234);
    chk_tx(4, 8'hBE, "R8");
    chk_tx(5, 8'hEF, "R8");
    run_frame(12, 0, 1, 0, -1, 0, 0);
    chk_tx(4, 8'h12, "R8");
    chk_tx(5, 8'h34, "R8");
  endtask

  task automatic t_disabled;  // R9
    terminal_cfg();
    ch_en_i[1] = 1'b0;
    fill_din(41);
    run_frame(12, 0, 1, 0, -1, 0, 0);
    chk_idle(1, "R9");
    chk_rx(1, 0, 0, "R9");
    chk_rx(0, 1, {8'h00, din_byte[0]}, "R9");
  endtask

  task automatic t_overlap;  // R10
    ch_en_i = '0;
    num_slots_i = 6'd4;
    cfg_ch(0, 1, 2, 0, 16'h0055);
    cfg_ch(1, 1, 2, 1, 16'h00AA);
    fill_din(53);
    run_frame(4, 0, 1, 0, -1, 0, 0);
    chk_tx(2, 8'h55, "R10");
    chk_rx(0, 1, {8'h00, din_byte[2]}, "R10");
    chk_rx(1, 1, {8'h00, din_byte[2]}, "R10");
    chk(vt[0] == vt[1], "R10", "same-cycle strobes", int'(vt[0]), int'(vt[1]));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_unsynced();
    t_single();
    t_double();
    t_strobe_shape();
    t_slot_limit();
    t_tx_latch();
    t_disabled();
    t_overlap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule